// File: doc/BRIEF.md
# Interrupt-Driven Receive Frame Queue

This block holds frames that a CAN-style controller has already received and accepted. It keeps them in arrival order and shows the oldest one at a single fixed output window. Each frame has an identifier, an extended-format flag, a remote-request flag, a length code and a payload. The host does not read the frame with a read strobe. It reads the window and then clears the frame-available interrupt. That clear removes the head frame, and the next stored frame appears in the window.

The queue raises three interrupts:
- a frame-available flag, which is high while anything is stored;
- a sticky warning, set when the occupancy climbs to the warning level;
- a sticky overflow, set when a frame arrives at a full queue and is discarded.

The whole queue works only while its enable input is high. Dropping the enable empties the queue and clears every flag.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset, all three interrupt outputs are 0 and the queue is empty.
- R2: While `enable_i` is 0, frame writes are ignored and all interrupt flags are held at 0. One cycle with `enable_i` at 0 discards all stored frames.
- R3: Frames leave in the order they were written. A frame written into an empty queue is shown on the head window in the cycle after its write strobe.
- R4: `irq_avail_o` is 1 exactly when at least one frame is stored.
- R5: A `clr_avail_i` strobe on a non-empty queue removes the head frame. The next frame is shown in the following cycle, and `irq_avail_o` stays 1 if frames remain.
- R6: The queue holds at most 6 frames (parameter DEPTH). A write to a full queue with no pop in the same cycle is dropped, sets `irq_ovf_o`, and leaves the stored frames unchanged.
- R7: `irq_warn_o` is set in the cycle after a write takes the occupancy from 3 to 4 (parameter WARN_LEVEL). It stays set while the occupancy falls again.
- R8: Warning and overflow flags stay set until their own clear strobe. A clear strobe in the same cycle as a new set event leaves the flag set.
- R9: A write and a `clr_avail_i` strobe in the same cycle on a full queue accept the new frame without setting `irq_ovf_o`. The occupancy stays at 6.
- R10: `clr_avail_i` on an empty queue has no effect.
- R11: Arrival order holds across any number of pointer wraps under interleaved writes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Queue enable; 0 flushes and holds the queue idle |
| wr_valid_i | input | 1 | One-cycle strobe: an accepted frame is offered |
| wr_id_i | input | 29 | Frame identifier |
| wr_ide_i | input | 1 | Extended-identifier flag |
| wr_rtr_i | input | 1 | Remote-request flag |
| wr_dlc_i | input | 4 | Data length code |
| wr_data_i | input | 64 | Payload bytes |
| clr_avail_i | input | 1 | Clear frame-available interrupt; pops the head |
| clr_warn_i | input | 1 | Clear warning interrupt |
| clr_ovf_i | input | 1 | Clear overflow interrupt |
| head_id_o | output | 29 | Identifier of the oldest frame |
| head_ide_o | output | 1 | Extended flag of the oldest frame |
| head_rtr_o | output | 1 | Remote flag of the oldest frame |
| head_dlc_o | output | 4 | Length code of the oldest frame |
| head_data_o | output | 64 | Payload of the oldest frame |
| irq_avail_o | output | 1 | Frame-available interrupt |
| irq_warn_o | output | 1 | Near-full warning interrupt |
| irq_ovf_o | output | 1 | Overflow interrupt |

## Verification
The bench sweeps every fill level from empty to full. At each level it applies every combination of write, pop and warning clear, and compares the window and all three flags against an arithmetic queue model.

Each corner case targets a specific fault:
- Push and pop together on a full queue: a design that tests fullness before the pop would raise a false overflow and lose the frame.
- Clear in the same cycle as a set event: a design where the clear wins would drop a warning or an overflow.
- Pop on an empty queue: a design that does not guard it would let the occupancy underflow.
- A long interleaved run: it wraps the pointers many times, so an off-by-one in the modulo-6 wrap shows up as frames out of order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ID_W  = 29;
  localparam int DLC_W = 4;
  localparam int PAY_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic             ide;
    logic             rtr;
    logic [DLC_W-1:0] dlc;
    logic [PAY_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  frame_t           wr_frame_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output frame_t           rd_frame_o
);
  frame_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slot_q[g] <= '0;
      else if (we_i && wr_ptr_i == PTR_W'(g))
        slot_q[g] <= wr_frame_i;
    end
  end

  assign rd_frame_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             wr_valid_i,
  input  logic             clr_avail_i,
  output logic             push_o,
  output logic             drop_o,
  output logic             warn_hit_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PRE_WARN = CNT_W'(WARN_LEVEL - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             pop, push, room;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign room = count_q != FULL_CNT;
  assign pop  = enable_i && clr_avail_i && count_q != '0;
  // a pop in the same cycle frees the slot for a push on a full queue
  assign push = enable_i && wr_valid_i && (room || pop);

  assign push_o     = push;
  assign drop_o     = enable_i && wr_valid_i && !room && !pop;
  assign warn_hit_o = push && !pop && count_q == PRE_WARN;
  assign wr_ptr_o   = wr_ptr_q;
  assign rd_ptr_o   = rd_ptr_q;
  assign count_o    = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (!enable_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      if (push && !pop)      count_q <= count_q + CNT_W'(1);
      else if (pop && !push) count_q <= count_q - CNT_W'(1);
    end
  end

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && wr_valid_i && !clr_avail_i && count_q == FULL_CNT |=> count_q == FULL_CNT);
  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !wr_valid_i && clr_avail_i && count_q == '0 |=> count_q == '0 && $stable(rd_ptr_q));
  // R2
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> count_q == '0);
  // R6
  bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic warn_hit_i,
  input  logic drop_i,
  input  logic clr_warn_i,
  input  logic clr_ovf_i,
  output logic warn_o,
  output logic ovf_o
);
  logic warn_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (!enable_i) begin
      warn_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      // set wins over clear
      warn_q <= warn_hit_i || (warn_q && !clr_warn_i);
      ovf_q  <= drop_i || (ovf_q && !clr_ovf_i);
    end
  end

  assign warn_o = warn_q;
  assign ovf_o  = ovf_q;

  // R8
  warn_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && warn_hit_i |=> warn_q);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && ovf_q && !clr_ovf_i |=> ovf_q);
  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && drop_i |=> ovf_q);
  // R2
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !warn_q && !ovf_q);
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              wr_valid_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic              wr_ide_i,
  input  logic              wr_rtr_i,
  input  logic [DLC_W-1:0]  wr_dlc_i,
  input  logic [PAY_W-1:0]  wr_data_i,
  input  logic              clr_avail_i,
  input  logic              clr_warn_i,
  input  logic              clr_ovf_i,
  output logic [ID_W-1:0]   head_id_o,
  output logic              head_ide_o,
  output logic              head_rtr_o,
  output logic [DLC_W-1:0]  head_dlc_o,
  output logic [PAY_W-1:0]  head_data_o,
  output logic              irq_avail_o,
  output logic              irq_warn_o,
  output logic              irq_ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             push, drop, warn_hit;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  frame_t           wr_frame, head;

  assign wr_frame = '{id: wr_id_i, ide: wr_ide_i, rtr: wr_rtr_i, dlc: wr_dlc_i, data: wr_data_i};

  rxq_ctrl #(.DEPTH(DEPTH), .WARN_LEVEL(WARN_LEVEL)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .wr_valid_i, .clr_avail_i,
    .push_o(push), .drop_o(drop), .warn_hit_o(warn_hit),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .count_o(count)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .we_i(push), .wr_ptr_i(wr_ptr), .wr_frame_i(wr_frame),
    .rd_ptr_i(rd_ptr), .rd_frame_o(head)
  );

  rxq_irq u_irq (
    .clk_i, .rst_ni, .enable_i, .warn_hit_i(warn_hit), .drop_i(drop),
    .clr_warn_i, .clr_ovf_i, .warn_o(irq_warn_o), .ovf_o(irq_ovf_o)
  );

  assign head_id_o   = head.id;
  assign head_ide_o  = head.ide;
  assign head_rtr_o  = head.rtr;
  assign head_dlc_o  = head.dlc;
  assign head_data_o = head.data;
  assign irq_avail_o = count != '0;

  // R9
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && wr_valid_i && clr_avail_i && count == FULL_CNT && !irq_ovf_o
    |=> !irq_ovf_o && irq_avail_o);
  // R5
  last_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && clr_avail_i && !wr_valid_i && count == CNT_W'(1) |=> !irq_avail_o);
  // R3
  first_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && wr_valid_i && !irq_avail_o |=> irq_avail_o && head_id_o == $past(wr_id_i));
endmodule

// File: tb/rx_frame_queue_bench.sv
module rx_frame_queue_bench;
  import rxq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, wr = 1'b0, ca = 1'b0, cw = 1'b0, co = 1'b0;
  frame_t wf = '0;
  logic [ID_W-1:0] h_id; logic h_ide, h_rtr; logic [DLC_W-1:0] h_dlc; logic [PAY_W-1:0] h_data;
  logic irq_a, irq_w, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int mq[$];
  bit mw = 0, mo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_queue u_rx_frame_queue (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .wr_valid_i(wr),
    .wr_id_i(wf.id), .wr_ide_i(wf.ide), .wr_rtr_i(wf.rtr), .wr_dlc_i(wf.dlc), .wr_data_i(wf.data),
    .clr_avail_i(ca), .clr_warn_i(cw), .clr_ovf_i(co),
    .head_id_o(h_id), .head_ide_o(h_ide), .head_rtr_o(h_rtr), .head_dlc_o(h_dlc), .head_data_o(h_data),
    .irq_avail_o(irq_a), .irq_warn_o(irq_w), .irq_ovf_o(irq_o)
  );

  function automatic frame_t gen(input int k);
    frame_t f;
    f.id   = ID_W'((k * 32'h9E3779B1) >> 3);
    f.ide  = k[0];
    f.rtr  = k[1];
    f.dlc  = DLC_W'(k % 9);
    f.data = {32'(k * 7919), ~32'(k)};
    return f;
  endfunction

  task automatic check(input string tag);
    logic [2:0] act_f, exp_f;
    frame_t act_h, exp_h;
    act_f = {irq_a, irq_w, irq_o};
    exp_f = {mq.size() > 0, mw, mo};
    act_h = {h_id, h_ide, h_rtr, h_dlc, h_data};
    exp_h = (mq.size() > 0) ? gen(mq[0]) : act_h;
    checks++;
    if (act_f !== exp_f || act_h !== exp_h) begin
      errors++;
      $display("FAIL %s: flags act=%b exp=%b head act=%h exp=%h", tag, act_f, exp_f, act_h, exp_h);
    end
  endtask

  // one clock: drive at negedge, update model, sample 1 time unit after posedge
  task automatic step(input bit e, input bit w, input int k, input bit a, input bit c_w,
                      input bit c_o, input string tag);
    bit pop, room, push, drop, wset;
    @(negedge clk);
    en = e; wr = w; wf = gen(k); ca = a; cw = c_w; co = c_o;
    if (!e) begin
      mq.delete(); mw = 0; mo = 0;
    end else begin
      pop  = a && mq.size() > 0;
      room = mq.size() < DEPTH;
      push = w && (room || pop);
      drop = w && !room && !pop;
      wset = push && !pop && mq.size() == 3;
      if (pop)  void'(mq.pop_front());
      if (push) mq.push_back(k);
      mw = wset || (mw && !c_w);
      mo = drop || (mo && !c_o);
    end
    @(posedge clk); #1;
    check(tag);
    @(negedge clk);
    wr = 0; ca = 0; cw = 0; co = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int key = 1;
    repeat (3) @(posedge clk);
    #1 check("R1");
    rst_n = 1'b1;
    @(posedge clk); #1 check("R1");

    // R2: writes while disabled are ignored
    step(0, 1, key++, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R2");

    // sweep all fill levels x write/pop/warn-clear combinations
    for (int lvl = 0; lvl <= DEPTH; lvl++)
      for (int op = 0; op < 4; op++)
        for (int c = 0; c < 2; c++) begin
          string tag;
          step(0, 0, 0, 0, 0, 0, "R2");
          for (int i = 0; i < lvl; i++) step(1, 1, key++, 0, 0, 0, (i == 3) ? "R7" : "R3");
          if (lvl == DEPTH && op == 1)      tag = "R6";
          else if (lvl == DEPTH && op == 3) tag = "R9";
          else if (lvl == 0 && op == 2)     tag = "R10";
          else if (lvl == 3 && op == 1)     tag = c ? "R8" : "R7";
          else                              tag = "R5";
          step(1, op[0], key++, op[1], c[0], 0, tag);
          while (mq.size() > 0) step(1, 0, 0, 1, 0, 0, "R4");
          step(1, 0, 0, 1, 0, 0, "R10");
        end

    // overflow stickiness, same-cycle clear and set
    step(0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < DEPTH; i++) step(1, 1, key++, 0, 0, 0, "R3");
    step(1, 1, key++, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(1, 1, key++, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 1, 0, "R8");
    step(0, 1, key++, 0, 0, 0, "R2");

    // interleaved traffic across many pointer wraps
    for (int i = 0; i < 600; i++)
      step(1, (i % 3) != 0, key++, (i % 5) < 2 || (i % 47) > 40, (i % 11) == 0, (i % 13) == 0, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule